// File: doc/BRIEF.md
# Grouped Interrupt Cause and Mask Controller

This block collects interrupt sources into a parameterized number of groups, each group a word of cause bits. Hardware event pulses set cause bits, and software reaches every group through one register port. On that port a group index and a register selector pick one of six views: cause, set-cause, mask, mask-clear, abort mask and control. Each group drives a registered interrupt line whenever any cause bit is pending while unmasked. A second registered line, meant for an attached DMA engine, is raised by the cause bits that the group's abort mask lets through.

Software unmasks bits with the write-one-to-clear mask view, so no read-modify-write is needed. This stays safe while the optional auto-mask mode sets mask bits from hardware in the same cycle. A per-group control register also enables clear-on-read for the cause view. Software can inject causes through the set-cause view to exercise handlers.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset every mask bit and every abort-mask bit is 1, every cause bit is 0, the control register is 0, and irq_o and abort_o are 0.
- R2: irq_o[g] equals the OR over the bits of (cause AND NOT mask) of group g as it stood one clock earlier, so a set mask bit blocks its cause.
- R3: Writing selector 3 (mask-clear) clears the mask bits written as 1 and leaves the bits written as 0 unchanged. A hardware auto-mask in the same cycle is kept. Reading selector 3 returns the mask.
- R4: Selector 2 reads and writes the whole mask word.
- R5: Writing selector 0 (cause) clears the cause bits written as 1.
- R6: Writing selector 1 (set-cause) sets the cause bits written as 1. Reading selector 1 returns the cause without clearing it.
- R7: When control bit 0 (clear-on-read) is 1, a read of selector 0 returns the cause and clears the returned bits at that clock. When control bit 0 is 0, reads leave the cause unchanged.
- R8: An event input bit that is 1 at a clock sets its cause bit, and this wins over a software clear of the same bit in the same cycle.
- R9: When control bit 1 (auto-mask) is 1, every cause bit that is pending and unmasked gets its mask bit set at the same clock edge at which irq_o rises for it.
- R10: Selector 4 reads and writes the abort mask. abort_o[g] equals the OR of (cause AND NOT abort mask) one clock earlier.
- R11: Selector 5 holds the 2-bit control word. reg_grp_i picks the group, and the other groups are unaffected. Selectors 6 and 7 read 0 and ignore writes. reg_rdata_o is 0 when reg_rd_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_grp_i | input | GRP_W | Group index |
| reg_sel_i | input | 3 | Register selector (0 cause, 1 set-cause, 2 mask, 3 mask-clear, 4 abort mask, 5 control) |
| reg_wdata_i | input | WIDTH | Write data |
| reg_rdata_o | output | WIDTH | Read data, combinational, valid while reg_rd_i is 1 |
| evt_i | input | N_GROUPS*WIDTH | Hardware event inputs, group g at bits g*WIDTH and up |
| irq_o | output | N_GROUPS | Registered interrupt per group |
| abort_o | output | N_GROUPS | Registered abort request per group |

## Verification
On every cycle the assertions check the following: the one-cycle relation between the pending bits and irq_o and abort_o, that a mask-clear write never clears a bit written as 0, that set-cause writes and event pulses always leave their bits set, and that auto-mask covers every bit that was pending. Some behaviours only the bench scenarios show. These are the value a clear-on-read returns and its clearing in one group but not another, the exact cycle at which a masked bit stops the interrupt, and the collision of a mask-clear with an auto-mask. They also cover an event winning over a clear, and the selectors that are ignored.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    SEL_CAUSE  = 3'd0,
    SEL_SET    = 3'd1,
    SEL_MASK   = 3'd2,
    SEL_UNMASK = 3'd3,
    SEL_ABORT  = 3'd4,
    SEL_CTRL   = 3'd5
  } reg_sel_e;

  localparam int CTRL_W    = 2;
  localparam int CTRL_COR  = 0;
  localparam int CTRL_AUTO = 1;
endpackage

// File: rtl/irq_grp_decode.sv
module irq_grp_decode #(
  parameter int N_GROUPS = 4,
  parameter int GRP_W    = 2
) (
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [GRP_W-1:0] grp_i,
  output logic [N_GROUPS-1:0] wr_o,
  output logic [N_GROUPS-1:0] rd_o
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_dec
    assign wr_o[g] = wr_i && (grp_i == GRP_W'(g));
    assign rd_o[g] = rd_i && (grp_i == GRP_W'(g));
  end
endmodule

// File: rtl/irq_group.sv
module irq_group
  import irq_ctrl_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  evt_i,
  output logic [WIDTH-1:0]  cause_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  abmask_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              irq_o,
  output logic              abort_o
);
  logic [WIDTH-1:0]  cause_q, mask_q, abmask_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [WIDTH-1:0]  sw_clr, cor_clr, sw_set, pend, auto_set;
  logic [WIDTH-1:0]  cause_d, mask_base, mask_d;
  logic              irq_q, abort_q;

  always_comb begin
    sw_clr   = (wr_i && sel_i == SEL_CAUSE) ? wdata_i : '0;
    cor_clr  = (rd_i && sel_i == SEL_CAUSE && ctrl_q[CTRL_COR]) ? cause_q : '0;
    sw_set   = (wr_i && sel_i == SEL_SET) ? wdata_i : '0;
    // events and sets override clears so no event is dropped
    cause_d  = (cause_q & ~(sw_clr | cor_clr)) | sw_set | evt_i;
    pend     = cause_q & ~mask_q;
    auto_set = ctrl_q[CTRL_AUTO] ? pend : '0;
    if (wr_i && sel_i == SEL_MASK)        mask_base = wdata_i;
    else if (wr_i && sel_i == SEL_UNMASK) mask_base = mask_q & ~wdata_i;
    else                                  mask_base = mask_q;
    mask_d   = mask_base | auto_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q  <= '0;
      mask_q   <= '1;
      abmask_q <= '1;
      ctrl_q   <= '0;
      irq_q    <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      if (wr_i && sel_i == SEL_ABORT) abmask_q <= wdata_i;
      if (wr_i && sel_i == SEL_CTRL)  ctrl_q   <= wdata_i[CTRL_W-1:0];
      irq_q   <= |pend;
      abort_q <= |(cause_q & ~abmask_q);
    end
  end

  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign abmask_o = abmask_q;
  assign ctrl_o   = ctrl_q;
  assign irq_o    = irq_q;
  assign abort_o  = abort_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_ctrl_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int WIDTH    = 32,
  parameter int GRP_W    = 2
) (
  input  logic                              rd_i,
  input  logic [GRP_W-1:0]                  grp_i,
  input  reg_sel_e                          sel_i,
  input  logic [N_GROUPS-1:0][WIDTH-1:0]    cause_i,
  input  logic [N_GROUPS-1:0][WIDTH-1:0]    mask_i,
  input  logic [N_GROUPS-1:0][WIDTH-1:0]    abmask_i,
  input  logic [N_GROUPS-1:0][CTRL_W-1:0]   ctrl_i,
  output logic [WIDTH-1:0]                  rdata_o
);
  logic [WIDTH-1:0]  cause_s, mask_s, abmask_s;
  logic [CTRL_W-1:0] ctrl_s;

  always_comb begin
    cause_s  = '0;
    mask_s   = '0;
    abmask_s = '0;
    ctrl_s   = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (grp_i == GRP_W'(g)) begin
        cause_s  = cause_i[g];
        mask_s   = mask_i[g];
        abmask_s = abmask_i[g];
        ctrl_s   = ctrl_i[g];
      end
    end
    rdata_o = '0;
    if (rd_i) begin
      case (sel_i)
        SEL_CAUSE, SEL_SET:  rdata_o = cause_s;
        SEL_MASK, SEL_UNMASK: rdata_o = mask_s;
        SEL_ABORT:           rdata_o = abmask_s;
        SEL_CTRL:            rdata_o = WIDTH'(ctrl_s);
        default:             rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int WIDTH    = 32,
  parameter int GRP_W    = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [GRP_W-1:0]          reg_grp_i,
  input  logic [2:0]                reg_sel_i,
  input  logic [WIDTH-1:0]          reg_wdata_i,
  output logic [WIDTH-1:0]          reg_rdata_o,
  input  logic [N_GROUPS*WIDTH-1:0] evt_i,
  output logic [N_GROUPS-1:0]       irq_o,
  output logic [N_GROUPS-1:0]       abort_o
);
  reg_sel_e                          sel;
  logic [N_GROUPS-1:0]               wr_g, rd_g;
  logic [N_GROUPS-1:0][WIDTH-1:0]    cause_a, mask_a, abmask_a;
  logic [N_GROUPS-1:0][CTRL_W-1:0]   ctrl_a;

  assign sel = reg_sel_e'(reg_sel_i);

  irq_grp_decode #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W)) i_dec (
    .wr_i  (reg_wr_i),
    .rd_i  (reg_rd_i),
    .grp_i (reg_grp_i),
    .wr_o  (wr_g),
    .rd_o  (rd_g)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    irq_group #(.WIDTH(WIDTH)) i_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_g[g]),
      .rd_i     (rd_g[g]),
      .sel_i    (sel),
      .wdata_i  (reg_wdata_i),
      .evt_i    (evt_i[g*WIDTH +: WIDTH]),
      .cause_o  (cause_a[g]),
      .mask_o   (mask_a[g]),
      .abmask_o (abmask_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .irq_o    (irq_o[g]),
      .abort_o  (abort_o[g])
    );
  end

  irq_read_mux #(.N_GROUPS(N_GROUPS), .WIDTH(WIDTH), .GRP_W(GRP_W)) i_rmux (
    .rd_i     (reg_rd_i),
    .grp_i    (reg_grp_i),
    .sel_i    (sel),
    .cause_i  (cause_a),
    .mask_i   (mask_a),
    .abmask_i (abmask_a),
    .ctrl_i   (ctrl_a),
    .rdata_o  (reg_rdata_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int WIDTH    = 32,
  parameter int GRP_W    = 2
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             reg_wr_i,
  input logic [GRP_W-1:0]                 reg_grp_i,
  input logic [2:0]                       reg_sel_i,
  input logic [WIDTH-1:0]                 reg_wdata_i,
  input logic [N_GROUPS*WIDTH-1:0]        evt_i,
  input logic [N_GROUPS-1:0]              irq_o,
  input logic [N_GROUPS-1:0]              abort_o,
  input logic [N_GROUPS-1:0][WIDTH-1:0]   cause_a,
  input logic [N_GROUPS-1:0][WIDTH-1:0]   mask_a,
  input logic [N_GROUPS-1:0][WIDTH-1:0]   abmask_a,
  input logic [N_GROUPS-1:0][CTRL_W-1:0]  ctrl_a
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
    logic hit;
    assign hit = reg_wr_i && (reg_grp_i == GRP_W'(g));

    p_irq_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> irq_o[g] == $past(|(cause_a[g] & ~mask_a[g])));

    p_unmask_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && reg_sel_i == 3'd3) |=>
        (($past(mask_a[g]) & ~$past(reg_wdata_i) & ~mask_a[g]) == '0));

    p_set_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && reg_sel_i == 3'd1) |=>
        ((cause_a[g] & $past(reg_wdata_i)) == $past(reg_wdata_i)));

    p_evt_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((cause_a[g] & $past(evt_i[g*WIDTH +: WIDTH])) ==
                $past(evt_i[g*WIDTH +: WIDTH])));

    p_auto_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_a[g][CTRL_AUTO] |=>
        ((mask_a[g] & $past(cause_a[g] & ~mask_a[g])) ==
         $past(cause_a[g] & ~mask_a[g])));

    p_abort_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> abort_o[g] == $past(|(cause_a[g] & ~abmask_a[g])));
  end
endmodule

bind irq_group_ctrl irq_ctrl_chk #(
  .N_GROUPS(N_GROUPS), .WIDTH(WIDTH), .GRP_W(GRP_W)
) i_chk (.*);

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;
  localparam int NG = 4;
  localparam int W  = 32;
  localparam int GW = 2;
  localparam int NV = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [GW-1:0] grp = '0;
  logic [2:0]    sel = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [NG*W-1:0] evt = '0;
  logic [NG-1:0] irq, abort_s;
  int total = 0, fails = 0;
  logic [W-1:0] got;

  always #5 clk = ~clk;

  irq_group_ctrl #(.N_GROUPS(NG), .WIDTH(W)) i_irq_group_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_grp_i(grp), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq), .abort_o(abort_s)
  );

  // {is_read, group, selector, wdata, expected}
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 2'd0, 3'd2, 32'h0,         32'hFFFF_FFFF}, // R1 mask
    {1'b1, 2'd0, 3'd0, 32'h0,         32'h0},         // R1 cause
    {1'b0, 2'd0, 3'd2, 32'h0000_00FF, 32'h0},
    {1'b1, 2'd0, 3'd2, 32'h0,         32'h0000_00FF}, // R4
    {1'b0, 2'd0, 3'd3, 32'h0000_000F, 32'h0},
    {1'b1, 2'd0, 3'd3, 32'h0,         32'h0000_00F0}, // R3
    {1'b0, 2'd1, 3'd1, 32'hA5A5_0000, 32'h0},
    {1'b1, 2'd1, 3'd1, 32'h0,         32'hA5A5_0000}, // R6
    {1'b0, 2'd1, 3'd0, 32'h0005_0000, 32'h0},
    {1'b1, 2'd1, 3'd0, 32'h0,         32'hA5A0_0000}, // R5
    {1'b1, 2'd2, 3'd0, 32'h0,         32'h0},         // R11 group isolation
    {1'b1, 2'd0, 3'd6, 32'h0,         32'h0},         // R11 unused selector
    {1'b0, 2'd2, 3'd5, 32'h0000_0001, 32'h0},
    {1'b0, 2'd2, 3'd1, 32'h0000_1234, 32'h0},
    {1'b1, 2'd2, 3'd0, 32'h0,         32'h0000_1234}, // R7 returns value
    {1'b1, 2'd2, 3'd0, 32'h0,         32'h0},         // R7 cleared
    {1'b1, 2'd1, 3'd0, 32'h0,         32'hA5A0_0000}, // R7 off in group 1
    {1'b0, 2'd3, 3'd4, 32'h0000_FFFE, 32'h0},
    {1'b1, 2'd3, 3'd4, 32'h0,         32'h0000_FFFE}, // R10
    {1'b1, 2'd3, 3'd5, 32'h0,         32'h0}          // R11 ctrl reset
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int g, input int s, input logic [W-1:0] d);
    @(negedge clk);
    wr = 1'b1; grp = GW'(g); sel = 3'(s); wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input int g, input int s, output logic [W-1:0] d);
    @(negedge clk);
    rd = 1'b1; grp = GW'(g); sel = 3'(s);
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq_o", W'(irq), '0);
    check("R1 abort_o", W'(abort_s), '0);
    check("R11 rdata idle", rdata, '0);

    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      v = VEC[i];
      if (v[69]) begin
        reg_rd(int'(v[68:67]), int'(v[66:64]), got);
        check($sformatf("vector %0d (R1..R11 table)", i), got, v[31:0]);
      end else begin
        reg_wr(int'(v[68:67]), int'(v[66:64]), v[63:32]);
      end
    end
    check("R2 all masked", W'(irq), '0);

    // R2: one-cycle latency, mask blocks
    reg_wr(1, 0, 32'hFFFF_FFFF);
    reg_wr(1, 2, 32'hFFFF_FFFE);
    reg_wr(1, 1, 32'h1);
    check("R2 before latency", W'(irq[1]), 0);
    @(negedge clk);
    check("R2 irq raised", W'(irq[1]), 1);
    reg_wr(1, 2, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R2 masked drops irq", W'(irq[1]), 0);

    // R10: abort path
    reg_wr(3, 1, 32'h2);
    @(negedge clk);
    check("R10 blocked by abort mask", W'(abort_s[3]), 0);
    reg_wr(3, 1, 32'h1);
    @(negedge clk);
    check("R10 abort raised", W'(abort_s[3]), 1);
    check("R2 irq stays masked", W'(irq[3]), 0);
    reg_wr(3, 0, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R10 abort cleared", W'(abort_s[3]), 0);

    // R8: event vs clear in the same cycle
    @(negedge clk);
    evt[4] = 1'b1; wr = 1'b1; grp = 2'd0; sel = 3'd0; wdata = 32'h10;
    @(negedge clk);
    evt = '0; wr = 1'b0; wdata = '0;
    reg_rd(0, 0, got);
    check("R8 event wins over clear", got, 32'h10);
    @(negedge clk);
    evt[7] = 1'b1;
    @(negedge clk);
    evt = '0;
    reg_rd(0, 0, got);
    check("R8 event latched", got, 32'h90);

    // R9 auto-mask with concurrent mask-clear (R3)
    reg_wr(0, 0, 32'hFF);
    reg_wr(0, 2, 32'hFFFF_FFFC);
    reg_wr(0, 5, 32'h2);
    @(negedge clk);
    evt[0] = 1'b1;
    @(negedge clk);
    evt = '0; wr = 1'b1; grp = 2'd0; sel = 3'd3; wdata = 32'h100;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    check("R9 irq pulse", W'(irq[0]), 1);
    reg_rd(0, 2, got);
    check("R3 R9 auto-mask kept with unmask", got, 32'hFFFF_FEFD);
    check("R9 irq drops after auto-mask", W'(irq[0]), 0);

    // R11: unused selector write ignored
    reg_wr(0, 7, 32'hFFFF_FFFF);
    reg_rd(0, 2, got);
    check("R11 sel7 mask untouched", got, 32'hFFFF_FEFD);
    reg_rd(0, 0, got);
    check("R11 sel7 cause untouched", got, 32'h1);
    reg_rd(0, 5, got);
    check("R11 ctrl readback", got, 32'h2);

    finish_run();
  end
endmodule